// File: doc/BRIEF.md
# Stub Level-2 Cache Controller Register Block

This block takes the place of a level-2 cache controller's register interface in a system that has no real cache behind it. Software can still program the control, auxiliary, latency and address-filter registers and read them back. It can read a fixed identification word and a cache-type word. Maintenance operations always report as finished. The block holds no tag or data storage and creates no memory traffic. It decodes register offsets, keeps register state and returns the values that driver code expects to see.

Requests use a single-cycle handshake. The requester drives `req_valid` for one clock together with `req_write`, an address and write data. One clock later the block answers with `rsp_valid`, the read data and an error flag. Only the low 12 bits of the address are decoded. The cache-type word has its own power-on value and is never cleared by the register reset. Each read of it ORs in a field taken from the auxiliary register, so bits accumulate across reads.

Top module: `l2stub_regs`

## Requirements
- R1: Only address bits [11:0] select a register. Any two addresses that share those bits reach the same register.
- R2: A read of offset 0x000 returns 0x410000C8.
- R3: Every offset from 0x730 up to 0x7FF inclusive reads as 0 with no error. Writes there change no register and raise no error. Offsets 0x72C and 0x800 lie outside this window.
- R4: The control register at 0x100 stores only write-data bit 0. Read-data bits [31:1] of this register are always 0.
- R5: After reset, the auxiliary register (0x104) reads 0x02020000. Control (0x100), tag latency (0x108), data latency (0x10C), filter low (0xC00) and filter high (0xC04) all read 0.
- R6: The tag latency, data latency, filter low and filter high registers store all 32 bits of a write and return them on read.
- R7: A read of 0x004 builds a 5-bit field f. f[4:2] holds auxiliary bits [19:17], f[1] is 0 and f[0] holds auxiliary bit 16. The read returns the stored cache-type word ORed with f shifted left by 18 and with f shifted left by 6. That result is also stored as the new cache-type word. Its power-on value is 0x1C100100.
- R8: Bits set in the cache-type word stay set. Later auxiliary writes do not clear them, and neither does reset.
- R9: Offsets 0xF40, 0xF60 and 0xF80 read as 0 and ignore writes, with no error.
- R10: Any access to an offset not listed in R2 to R9 returns 0 and changes no register. So does a write to the read-only offsets 0x000 and 0x004. Each such access sets `rsp_err` for exactly the one response cycle of that access.
- R11: `rsp_valid` is high in the cycle after each accepted request and low otherwise. Write responses carry read data 0. During reset all three response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; bits [11:0] decoded |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| rsp_err | output | 1 | Access hit an unknown or read-only offset |

## Verification
The bound checker tests the response timing of R11 on every cycle. It also checks that the error flag only appears with a response, the constant identification readback, the all-zero maintenance window and the single stored control bit. Cache-type accumulation (R7, R8) depends on a history of auxiliary writes and type reads, and it must survive a reset. Only the bench's ordered scenarios can show this. The same holds for address aliasing, for full-width storage in the latency and filter registers, and for the fact that ignored writes leave every register unchanged.

// File: rtl/l2stub_pkg.sv
package l2stub_pkg;
    localparam int DATA_W = 32;
    localparam int OFS_W  = 12;

    typedef logic [OFS_W-1:0]  ofs_t;
    typedef logic [DATA_W-1:0] word_t;

    localparam word_t ID_WORD  = 32'h4100_00C8;
    localparam word_t AUX_RST  = 32'h0202_0000;

    localparam ofs_t OFS_ID     = 12'h000;
    localparam ofs_t OFS_TYPE   = 12'h004;
    localparam ofs_t OFS_CTRL   = 12'h100;
    localparam ofs_t OFS_AUX    = 12'h104;
    localparam ofs_t OFS_TAGLAT = 12'h108;
    localparam ofs_t OFS_DATLAT = 12'h10C;
    localparam ofs_t OFS_FLT_LO = 12'hC00;
    localparam ofs_t OFS_FLT_HI = 12'hC04;
    localparam ofs_t MAINT_LO   = 12'h730;
    localparam ofs_t MAINT_HI   = 12'h800;

    localparam int NUM_SINKS = 3;
    localparam ofs_t SINK_OFS [NUM_SINKS] = '{12'hF40, 12'hF60, 12'hF80};

    // Shift positions where the auxiliary-derived field is merged
    localparam int FOLD_W     = 5;
    localparam int FOLD_SH_HI = 18;
    localparam int FOLD_SH_LO = 6;

    typedef enum logic [3:0] {
        SEL_ID, SEL_TYPE, SEL_CTRL, SEL_AUX, SEL_TAGLAT, SEL_DATLAT,
        SEL_FLT_LO, SEL_FLT_HI, SEL_MAINT, SEL_SINK, SEL_BAD
    } sel_e;

    typedef struct packed {
        logic  valid;
        logic  write;
        sel_e  sel;
        word_t wdata;
    } acc_t;

    typedef struct packed {
        logic  ctrl;
        word_t aux;
        word_t taglat;
        word_t datlat;
        word_t flt_lo;
        word_t flt_hi;
    } cfg_t;

    typedef struct packed {
        logic  valid;
        logic  err;
        word_t rdata;
    } rsp_t;

    function automatic logic [FOLD_W-1:0] type_fold(input word_t aux);
        return {aux[19:17], 1'b0, aux[16]};
    endfunction

    function automatic word_t type_merge(input word_t cur, input word_t aux);
        word_t f;
        f = word_t'(type_fold(aux));
        return cur | (f << FOLD_SH_HI) | (f << FOLD_SH_LO);
    endfunction

    function automatic logic is_readonly(input sel_e s);
        return (s == SEL_ID) || (s == SEL_TYPE);
    endfunction
endpackage

// File: rtl/l2stub_decode.sv
module l2stub_decode
    import l2stub_pkg::*;
(
    input  ofs_t ofs,
    output sel_e sel
);
    logic [NUM_SINKS-1:0] sink_hit;

    for (genvar i = 0; i < NUM_SINKS; i++) begin : g_sink
        assign sink_hit[i] = (ofs == SINK_OFS[i]);
    end

    logic in_maint;
    assign in_maint = (ofs >= MAINT_LO) && (ofs < MAINT_HI);

    always_comb begin
        if (in_maint) begin
            sel = SEL_MAINT;
        end else if (|sink_hit) begin
            sel = SEL_SINK;
        end else begin
            unique case (ofs)
                OFS_ID:     sel = SEL_ID;
                OFS_TYPE:   sel = SEL_TYPE;
                OFS_CTRL:   sel = SEL_CTRL;
                OFS_AUX:    sel = SEL_AUX;
                OFS_TAGLAT: sel = SEL_TAGLAT;
                OFS_DATLAT: sel = SEL_DATLAT;
                OFS_FLT_LO: sel = SEL_FLT_LO;
                OFS_FLT_HI: sel = SEL_FLT_HI;
                default:    sel = SEL_BAD;
            endcase
        end
    end
endmodule

// File: rtl/l2stub_cfg.sv
module l2stub_cfg
    import l2stub_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  acc_t acc,
    output cfg_t cfg
);
    logic wr;
    assign wr = acc.valid && acc.write;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.ctrl   <= 1'b0;
            cfg.aux    <= AUX_RST;
            cfg.taglat <= '0;
            cfg.datlat <= '0;
            cfg.flt_lo <= '0;
            cfg.flt_hi <= '0;
        end else if (wr) begin
            case (acc.sel)
                SEL_CTRL:   cfg.ctrl   <= acc.wdata[0];
                SEL_AUX:    cfg.aux    <= acc.wdata;
                SEL_TAGLAT: cfg.taglat <= acc.wdata;
                SEL_DATLAT: cfg.datlat <= acc.wdata;
                SEL_FLT_LO: cfg.flt_lo <= acc.wdata;
                SEL_FLT_HI: cfg.flt_hi <= acc.wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/l2stub_typeword.sv
module l2stub_typeword
    import l2stub_pkg::*;
#(
    parameter word_t TYPE_INIT = 32'h1C10_0100
) (
    input  logic  clk,
    input  logic  upd,
    input  word_t aux,
    output word_t type_next
);
    // Power-on value only; deliberately outside the register reset
    word_t type_q = TYPE_INIT;

    assign type_next = type_merge(type_q, aux);

    always_ff @(posedge clk) begin
        if (upd) type_q <= type_next;
    end
endmodule

// File: rtl/l2stub_regs.sv
module l2stub_regs
    import l2stub_pkg::*;
#(
    parameter int    ADDR_W    = 32,
    parameter word_t TYPE_INIT = 32'h1C10_0100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err
);
    sel_e  sel;
    acc_t  acc;
    cfg_t  cfg;
    word_t type_next;
    rsp_t  rsp_d, rsp_q;
    logic  type_rd;

    l2stub_decode u_dec (
        .ofs (req_addr[OFS_W-1:0]),
        .sel (sel)
    );

    assign acc = '{valid: req_valid, write: req_write, sel: sel, wdata: req_wdata};

    l2stub_cfg u_cfg (
        .clk (clk),
        .rst (rst),
        .acc (acc),
        .cfg (cfg)
    );

    assign type_rd = !rst && acc.valid && !acc.write && (acc.sel == SEL_TYPE);

    l2stub_typeword #(.TYPE_INIT(TYPE_INIT)) u_type (
        .clk       (clk),
        .upd       (type_rd),
        .aux       (cfg.aux),
        .type_next (type_next)
    );

    always_comb begin
        rsp_d.valid = acc.valid;
        rsp_d.err   = acc.valid && ((acc.sel == SEL_BAD) ||
                                    (acc.write && is_readonly(acc.sel)));
        rsp_d.rdata = '0;
        if (acc.valid && !acc.write) begin
            case (acc.sel)
                SEL_ID:     rsp_d.rdata = ID_WORD;
                SEL_TYPE:   rsp_d.rdata = type_next;
                SEL_CTRL:   rsp_d.rdata = word_t'(cfg.ctrl);
                SEL_AUX:    rsp_d.rdata = cfg.aux;
                SEL_TAGLAT: rsp_d.rdata = cfg.taglat;
                SEL_DATLAT: rsp_d.rdata = cfg.datlat;
                SEL_FLT_LO: rsp_d.rdata = cfg.flt_lo;
                SEL_FLT_HI: rsp_d.rdata = cfg.flt_hi;
                default:    rsp_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= '0;
        else     rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.rdata;
endmodule

// File: rtl/l2stub_regs_chk.sv
module l2stub_regs_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic [31:0]       rsp_rdata,
    input logic              rsp_err
);
    logic rd_id, rd_maint, rd_ctrl;
    assign rd_id    = req_valid && !req_write && (req_addr[11:0] == 12'h000);
    assign rd_ctrl  = req_valid && !req_write && (req_addr[11:0] == 12'h100);
    assign rd_maint = req_valid && (req_addr[11:0] >= 12'h730) && (req_addr[11:0] < 12'h800);

    a_r11_rsp_after_req: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    a_r11_no_rsp_idle: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    a_r11_write_rdata_zero: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |=> (rsp_rdata == 32'h0));
    a_r10_err_with_rsp: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> rsp_valid);
    a_r2_id_word: assert property (@(posedge clk) disable iff (rst)
        rd_id |=> (rsp_rdata == 32'h4100_00C8 && !rsp_err));
    a_r3_maint_done: assert property (@(posedge clk) disable iff (rst)
        rd_maint |=> (rsp_rdata == 32'h0 && !rsp_err));
    a_r4_ctrl_one_bit: assert property (@(posedge clk) disable iff (rst)
        rd_ctrl |=> (rsp_rdata[31:1] == 31'h0));
endmodule

bind l2stub_regs l2stub_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err)
);

// File: tb/l2stub_regs_test.sv
`timescale 1ns/1ps
module l2stub_regs_test;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid;
    logic [31:0]       rsp_rdata;
    logic              rsp_err;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [31:0] rdata;
        logic        err;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    l2stub_regs #(.ADDR_W(ADDR_W)) uut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err)
    );

    // Monitor: pop one expectation per response, sampled on the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            if (rsp_valid) begin
                n_vec++;
                if (sb.size() == 0) begin
                    n_bad++;
                    $display("FAIL R11 unexpected response rdata=%h err=%b exp=none", rsp_rdata, rsp_err);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (rsp_rdata !== e.rdata || rsp_err !== e.err) begin
                        n_bad++;
                        $display("FAIL %s rdata=%h err=%b exp rdata=%h err=%b",
                                 e.tag, rsp_rdata, rsp_err, e.rdata, e.err);
                    end
                end
            end else if (rsp_err) begin
                n_vec++;
                n_bad++;
                $display("FAIL R10 err without response got=1 exp=0");
            end
        end
    end

    task automatic access(input bit wr, input logic [ADDR_W-1:0] a, input logic [31:0] wd,
                          input logic [31:0] er, input logic ee, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = wd;
        e.rdata = er;
        e.err   = ee;
        e.tag   = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            req_write = 1'b0;
        end
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] er, input logic ee, input string tag);
        access(1'b0, a, 32'h0, er, ee, tag);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] wd, input logic ee, input string tag);
        access(1'b1, a, wd, 32'h0, ee, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        req_valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        n_vec++;
        if (rsp_valid !== 1'b0 || rsp_err !== 1'b0 || rsp_rdata !== 32'h0) begin
            n_bad++;
            $display("FAIL R11 reset outputs v=%b e=%b d=%h exp 0 0 0", rsp_valid, rsp_err, rsp_rdata);
        end
        rst = 1'b0;
    endtask

    initial begin
        do_reset();

        rd(32'h0000_0000, 32'h4100_00C8, 1'b0, "R2 id word");
        rd(32'hABCD_E000, 32'h4100_00C8, 1'b0, "R1 alias id");
        rd(32'h0000_0104, 32'h0202_0000, 1'b0, "R5 aux reset");
        rd(32'h0000_0100, 32'h0, 1'b0, "R5 ctrl reset");
        rd(32'h0000_0108, 32'h0, 1'b0, "R5 taglat reset");
        rd(32'h0000_010C, 32'h0, 1'b0, "R5 datlat reset");
        rd(32'h0000_0C00, 32'h0, 1'b0, "R5 flt_lo reset");
        rd(32'h0000_0C04, 32'h0, 1'b0, "R5 flt_hi reset");
        rd(32'h0000_0004, 32'h1C10_0100, 1'b0, "R7 type power-on");

        wr(32'h0000_0100, 32'hFFFF_FFFE, 1'b0, "R4 ctrl write even");
        rd(32'h0000_0100, 32'h0, 1'b0, "R4 ctrl bit0 clear");
        wr(32'h0000_0100, 32'hFFFF_FFFF, 1'b0, "R4 ctrl write ones");
        rd(32'h0000_0100, 32'h1, 1'b0, "R4 ctrl bit0 only");
        rd(32'h0007_7100, 32'h1, 1'b0, "R1 alias ctrl");

        wr(32'h0000_0108, 32'hDEAD_BEEF, 1'b0, "R6 taglat write");
        wr(32'h0000_010C, 32'h1234_5678, 1'b0, "R6 datlat write");
        wr(32'h0000_0C00, 32'hA5A5_A5A5, 1'b0, "R6 flt_lo write");
        wr(32'h1000_0C04, 32'hFFFF_FFFF, 1'b0, "R6 flt_hi write alias");
        rd(32'h0000_0108, 32'hDEAD_BEEF, 1'b0, "R6 taglat read");
        rd(32'h0000_010C, 32'h1234_5678, 1'b0, "R6 datlat read");
        rd(32'h0000_0C00, 32'hA5A5_A5A5, 1'b0, "R6 flt_lo read");
        rd(32'h0000_0C04, 32'hFFFF_FFFF, 1'b0, "R6 flt_hi read");

        wr(32'h0000_0730, 32'hFFFF_FFFF, 1'b0, "R3 maint write lo");
        wr(32'h0000_07FC, 32'h0000_0000, 1'b0, "R3 maint write hi");
        rd(32'h0000_0730, 32'h0, 1'b0, "R3 maint read lo");
        rd(32'h0000_077C, 32'h0, 1'b0, "R3 maint read mid");
        rd(32'h0000_07FC, 32'h0, 1'b0, "R3 maint read hi");
        rd(32'h0000_072C, 32'h0, 1'b1, "R3 below window is unknown");
        rd(32'h0000_0800, 32'h0, 1'b1, "R3 window end is unknown");
        rd(32'h0000_0100, 32'h1, 1'b0, "R3 ctrl intact");
        rd(32'h0000_0108, 32'hDEAD_BEEF, 1'b0, "R3 taglat intact");

        wr(32'h0000_0F40, 32'h1111_1111, 1'b0, "R9 sink F40 write");
        wr(32'h0000_0F60, 32'h2222_2222, 1'b0, "R9 sink F60 write");
        wr(32'h0000_0F80, 32'h3333_3333, 1'b0, "R9 sink F80 write");
        rd(32'h0000_0F40, 32'h0, 1'b0, "R9 sink F40 read");
        rd(32'h0000_0F60, 32'h0, 1'b0, "R9 sink F60 read");
        rd(32'h0000_0F80, 32'h0, 1'b0, "R9 sink F80 read");

        rd(32'h0000_0110, 32'h0, 1'b1, "R10 unknown read");
        idle(1);
        wr(32'h0000_0110, 32'hCAFE_F00D, 1'b1, "R10 unknown write");
        wr(32'h0000_0F44, 32'hCAFE_F00D, 1'b1, "R10 near-sink write");
        wr(32'h0000_0000, 32'h0, 1'b1, "R10 id write");
        wr(32'h0000_0004, 32'hFFFF_FFFF, 1'b1, "R10 type write");
        rd(32'h0000_0000, 32'h4100_00C8, 1'b0, "R10 id intact");
        rd(32'h0000_0004, 32'h1C10_0100, 1'b0, "R10 type intact");
        rd(32'h0000_010C, 32'h1234_5678, 1'b0, "R10 datlat intact");

        wr(32'h0000_0104, 32'h0001_0000, 1'b0, "R7 aux bit16");
        rd(32'h0000_0004, 32'h1C14_0140, 1'b0, "R7 fold bit16");
        wr(32'h0000_0104, 32'h000F_0000, 1'b0, "R7 aux bits19-16");
        rd(32'h0000_0104, 32'h000F_0000, 1'b0, "R7 aux readback");
        rd(32'h0000_0004, 32'h1C74_0740, 1'b0, "R7 fold full");
        wr(32'h0000_0104, 32'h0000_0000, 1'b0, "R8 aux clear");
        rd(32'h0000_0004, 32'h1C74_0740, 1'b0, "R8 bits kept after aux clear");
        idle(3);

        do_reset();
        rd(32'h0000_0004, 32'h1C74_0740, 1'b0, "R8 bits kept after reset");
        rd(32'h0000_0104, 32'h0202_0000, 1'b0, "R5 aux reset again");
        rd(32'h0000_0100, 32'h0, 1'b0, "R5 ctrl reset again");
        rd(32'h0000_0C00, 32'h0, 1'b0, "R5 flt_lo reset again");
        idle(4);

        if (sb.size() != 0) begin
            n_vec++;
            n_bad++;
            $display("FAIL R11 missing responses got=%0d pending exp=0", sb.size());
        end
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL R11 watchdog expired got=%0d cycles exp=completion", cyc);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule